// File: doc/BRIEF.md
# Video Output Data Switch

This block is the last digital stage before three separate converter channels: one for luma and one each for the two colour-difference components. It takes a luma sample of up to ten bits, since a peaking stage upstream may push it past the nine-bit output range. It also takes two eight-bit colour-difference samples in offset-binary coding, where code 128 means no colour.

The block fits the luma sample to the nine-bit converter range. It can reverse the polarity of both colour-difference channels by flipping every bit. It has a colour-kill override that forces both channels to the no-colour code, and a per-sample blanking strobe that forces luma to a programmable black code and both chroma channels to no-colour.

Blanking overrides every other mode. Colour kill is applied after the polarity flip, so the no-colour code stays exactly 128 and never becomes 127. All results are registered once, with a valid strobe that follows the input strobe by one clock. The static controls come from a register file outside this block.

Top module: `vout_data_switch`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier, so every accepted sample appears exactly one clock later.
- R2: While `rst` is high, at the next clock `out_valid` becomes 0, `y_out` becomes 0, and `u_out` and `v_out` become 128.
- R3: With `peak_en` = 1 and no override, `y_out` equals `y_in` when `y_in` is at most 511, and 511 when `y_in` is above 511.
- R4: With `peak_en` = 0 and no blanking, `y_out` equals `y_in[7:0]` zero-extended to nine bits; bits 9 and 8 of `y_in` are ignored.
- R5: With `chroma_inv` = 1 and neither colour kill nor blanking, `u_out` and `v_out` are the bitwise complements of `u_in` and `v_in` (so 128 becomes 127). With `chroma_inv` = 0, the two samples pass through unchanged.
- R6: With `chroma_kill` = 1 and no blanking, `u_out` and `v_out` are 128 whatever `chroma_inv` is, and luma still follows R3 or R4.
- R7: A sample accepted with `in_blank` = 1 gives `y_out` = `black_level` and `u_out` = `v_out` = 128, regardless of `peak_en`, `chroma_kill` and `chroma_inv`.
- R8: In a clock where `in_valid` is 0, `y_out`, `u_out` and `v_out` keep their previous values; `in_blank` and the data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_blank | input | 1 | Blanking request for this sample |
| y_in | input | 10 | Luma sample, possibly over range after peaking |
| u_in | input | 8 | First colour-difference sample, offset binary |
| v_in | input | 8 | Second colour-difference sample, offset binary |
| peak_en | input | 1 | 1: keep the extended luma range with saturation; 0: use only the 8 low bits |
| chroma_kill | input | 1 | Force colour-difference outputs to no-colour |
| chroma_inv | input | 1 | Bitwise inversion of both colour-difference outputs |
| black_level | input | 9 | Luma code sent during blanking |
| out_valid | output | 1 | Output sample strobe |
| y_out | output | 9 | Luma to its converter |
| u_out | output | 8 | First colour-difference value to its converter |
| v_out | output | 8 | Second colour-difference value to its converter |

## Verification
The hardest situations to reach are the ones where modes overlap: an input chroma of exactly 128 with inversion on, once with colour kill on and once with it off, and blanking asserted with every other override also active. The stimulus steps through every combination of the three static controls while it drives those chroma codes in directed samples. The luma saturation edge needs inputs of exactly 511, 512 and 1023, with peaking both on and off, and the stimulus drives these directly. Gaps in the input strobe are also placed straight after such samples, with a changed blanking request and changed data. This shows that an idle clock disturbs nothing.

// File: rtl/vout_pkg.sv
package vout_pkg;
  parameter int YIN_W = 10;  // luma input width incl. peaking headroom
  parameter int Y_W   = 9;   // luma output width
  parameter int LO_W  = 8;   // luma width when peaking is off
  parameter int C_W   = 8;   // colour-difference width
  parameter int NUM_C = 2;   // number of colour-difference channels

  function automatic logic [C_W-1:0] no_colour_code();
    return C_W'(1) << (C_W - 1);
  endfunction
endpackage

// File: rtl/vout_luma_adapt.sv
module vout_luma_adapt #(
  parameter int YIN_W = vout_pkg::YIN_W,
  parameter int Y_W   = vout_pkg::Y_W,
  parameter int LO_W  = vout_pkg::LO_W
) (
  input  logic [YIN_W-1:0] y_in,
  input  logic             peak_en,
  input  logic             blank,
  input  logic [Y_W-1:0]   black_level,
  output logic [Y_W-1:0]   y_next
);
  localparam logic [YIN_W-1:0] LIMIT = YIN_W'((1 << Y_W) - 1);

  logic             over;
  logic [Y_W-1:0]   ranged;

  always_comb begin
    over = (y_in > LIMIT);
    if (peak_en) begin
      ranged = over ? {Y_W{1'b1}} : y_in[Y_W-1:0];
    end else begin
      ranged = Y_W'(y_in[LO_W-1:0]);
    end
    y_next = blank ? black_level : ranged;
  end
endmodule

// File: rtl/vout_chroma_cond.sv
module vout_chroma_cond #(
  parameter int C_W = vout_pkg::C_W
) (
  input  logic [C_W-1:0] c_in,
  input  logic           inv,
  input  logic           kill,
  input  logic           blank,
  output logic [C_W-1:0] c_next
);
  localparam logic [C_W-1:0] MID = C_W'(1) << (C_W - 1);

  logic [C_W-1:0] c_pol;

  always_comb begin
    // polarity flip first, override last: no-colour stays exact
    c_pol  = inv ? ~c_in : c_in;
    c_next = (blank || kill) ? MID : c_pol;
  end
endmodule

// File: rtl/vout_out_reg.sv
module vout_out_reg #(
  parameter int Y_W   = vout_pkg::Y_W,
  parameter int C_W   = vout_pkg::C_W,
  parameter int NUM_C = vout_pkg::NUM_C
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld,
  input  logic [Y_W-1:0]            y_d,
  input  logic [NUM_C-1:0][C_W-1:0] c_d,
  output logic                      vld_q,
  output logic [Y_W-1:0]            y_q,
  output logic [NUM_C-1:0][C_W-1:0] c_q
);
  localparam logic [C_W-1:0] MID = C_W'(1) << (C_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      y_q   <= '0;
    end else begin
      vld_q <= ld;
      if (ld) y_q <= y_d;
    end
  end

  for (genvar g = 0; g < NUM_C; g++) begin : g_creg
    always_ff @(posedge clk) begin
      if (rst)     c_q[g] <= MID;
      else if (ld) c_q[g] <= c_d[g];
    end
  end
endmodule

// File: rtl/vout_data_switch.sv
module vout_data_switch #(
  parameter int YIN_W = vout_pkg::YIN_W,
  parameter int Y_W   = vout_pkg::Y_W,
  parameter int LO_W  = vout_pkg::LO_W,
  parameter int C_W   = vout_pkg::C_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_blank,
  input  logic [YIN_W-1:0] y_in,
  input  logic [C_W-1:0]   u_in,
  input  logic [C_W-1:0]   v_in,
  input  logic             peak_en,
  input  logic             chroma_kill,
  input  logic             chroma_inv,
  input  logic [Y_W-1:0]   black_level,
  output logic             out_valid,
  output logic [Y_W-1:0]   y_out,
  output logic [C_W-1:0]   u_out,
  output logic [C_W-1:0]   v_out
);
  localparam int NCH = 2;

  logic [Y_W-1:0]          y_next;
  logic [NCH-1:0][C_W-1:0] c_in_bus;
  logic [NCH-1:0][C_W-1:0] c_next;
  logic [NCH-1:0][C_W-1:0] c_reg;

  assign c_in_bus[0] = u_in;
  assign c_in_bus[1] = v_in;

  vout_luma_adapt #(.YIN_W(YIN_W), .Y_W(Y_W), .LO_W(LO_W)) u_luma (
    .y_in        (y_in),
    .peak_en     (peak_en),
    .blank       (in_blank),
    .black_level (black_level),
    .y_next      (y_next)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chroma
    vout_chroma_cond #(.C_W(C_W)) u_cc (
      .c_in   (c_in_bus[ch]),
      .inv    (chroma_inv),
      .kill   (chroma_kill),
      .blank  (in_blank),
      .c_next (c_next[ch])
    );
  end

  vout_out_reg #(.Y_W(Y_W), .C_W(C_W), .NUM_C(NCH)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .ld    (in_valid),
    .y_d   (y_next),
    .c_d   (c_next),
    .vld_q (out_valid),
    .y_q   (y_out),
    .c_q   (c_reg)
  );

  assign u_out = c_reg[0];
  assign v_out = c_reg[1];
endmodule

// File: rtl/vout_data_switch_chk.sv
module vout_data_switch_chk #(
  parameter int YIN_W = vout_pkg::YIN_W,
  parameter int Y_W   = vout_pkg::Y_W,
  parameter int C_W   = vout_pkg::C_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_blank,
  input logic [YIN_W-1:0] y_in,
  input logic [C_W-1:0]   u_in,
  input logic [C_W-1:0]   v_in,
  input logic             peak_en,
  input logic             chroma_kill,
  input logic             chroma_inv,
  input logic [Y_W-1:0]   black_level,
  input logic             out_valid,
  input logic [Y_W-1:0]   y_out,
  input logic [C_W-1:0]   u_out,
  input logic [C_W-1:0]   v_out
);
  localparam logic [C_W-1:0]   MID  = C_W'(1) << (C_W - 1);
  localparam logic [YIN_W-1:0] YLIM = YIN_W'((1 << Y_W) - 1);

  p_valid_on_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_off_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_blank && peak_en && (y_in > YLIM)) |=> (y_out == {Y_W{1'b1}}));
  p_invert_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_blank && !chroma_kill && chroma_inv)
      |=> (u_out == ~$past(u_in)) && (v_out == ~$past(v_in)));
  p_kill_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && chroma_kill) |=> (u_out == MID) && (v_out == MID));
  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_blank)
      |=> (y_out == $past(black_level)) && (u_out == MID) && (v_out == MID));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(y_out) && $stable(u_out) && $stable(v_out));
endmodule

bind vout_data_switch vout_data_switch_chk #(
  .YIN_W(YIN_W), .Y_W(Y_W), .C_W(C_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_blank(in_blank),
  .y_in(y_in), .u_in(u_in), .v_in(v_in), .peak_en(peak_en),
  .chroma_kill(chroma_kill), .chroma_inv(chroma_inv),
  .black_level(black_level), .out_valid(out_valid), .y_out(y_out),
  .u_out(u_out), .v_out(v_out)
);

// File: tb/vout_data_switch_bench.sv
module vout_data_switch_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_blank = 1'b0;
  logic [9:0] y_in = '0;
  logic [7:0] u_in = '0, v_in = '0;
  logic       peak_en = 1'b0, chroma_kill = 1'b0, chroma_inv = 1'b0;
  logic [8:0] black_level = 9'd16;
  logic       out_valid;
  logic [8:0] y_out;
  logic [7:0] u_out, v_out;

  int compared = 0, mismatched = 0;
  bit done = 0, started = 0;
  int e_vld, e_y, e_u, e_v;
  string tag = "R2";
  int unsigned lfsr = 32'h1ACE_5EED;

  always #5 clk = ~clk;

  vout_data_switch u_vout_data_switch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_blank(in_blank),
    .y_in(y_in), .u_in(u_in), .v_in(v_in), .peak_en(peak_en),
    .chroma_kill(chroma_kill), .chroma_inv(chroma_inv),
    .black_level(black_level), .out_valid(out_valid), .y_out(y_out),
    .u_out(u_out), .v_out(v_out)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      e_vld = 0; e_y = 0; e_u = 128; e_v = 128; tag = "R2";
    end else begin
      e_vld = in_valid;
      if (!in_valid) tag = "R8";
      else if (in_blank) begin
        e_y = black_level; e_u = 128; e_v = 128; tag = "R7";
      end else begin
        if (peak_en) e_y = (int'(y_in) > 511) ? 511 : int'(y_in);
        else         e_y = int'(y_in) % 256;
        if (chroma_kill) begin e_u = 128; e_v = 128; tag = "R6"; end
        else if (chroma_inv) begin e_u = 255 - u_in; e_v = 255 - v_in; tag = "R5"; end
        else begin e_u = u_in; e_v = v_in; tag = peak_en ? "R3" : "R4"; end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      compared++;
      if (out_valid !== 1'(e_vld)) begin
        mismatched++;
        $display("FAIL R1 valid: got %0b expected %0d", out_valid, e_vld);
      end
      compared++;
      if (y_out !== 9'(e_y) || u_out !== 8'(e_u) || v_out !== 8'(e_v)) begin
        mismatched++;
        $display("FAIL %s data: got y=%0d u=%0d v=%0d expected y=%0d u=%0d v=%0d",
                 tag, y_out, u_out, v_out, e_y, e_u, e_v);
      end
    end
  end

  function automatic int unsigned step(int unsigned s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic put(bit vl, bit bl, int y, int u, int v);
    @(negedge clk);
    in_valid = vl; in_blank = bl;
    y_in = 10'(y); u_in = 8'(u); v_in = 8'(v);
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = step(lfsr);
      put(lfsr[3:0] != 4'd0, lfsr[7:4] == 4'd0,
          int'(lfsr[17:8]), int'(lfsr[25:18]), int'(lfsr[31:24]));
    end
  endtask

  task automatic directed();
    put(1, 0, 511, 128, 127);
    put(1, 0, 512, 0, 255);
    put(1, 0, 1023, 128, 1);
    put(0, 1, 77, 3, 9);    // R8: idle clock, blank request ignored
    put(1, 0, 255, 200, 56);
    put(1, 0, 256, 128, 128);
    put(1, 1, 1023, 128, 0);
    put(0, 0, 300, 250, 5); // R8
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      peak_en = m[0]; chroma_inv = m[1]; chroma_kill = m[2];
      black_level = (m % 3 == 0) ? 9'd511 : (m % 3 == 1) ? 9'd0 : 9'd16;
      directed();
      burst(40);
    end
    put(0, 0, 0, 0, 0);
    rst = 1'b1;           // mid-run reset back to R2 state
    put(0, 0, 0, 0, 0);
    put(0, 0, 0, 0, 0);
    rst = 1'b0;
    burst(20);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule